// File: doc/BRIEF.md
# Hamming (7,4) Single-Error Codec

This block pairs a combinational encoder with a combinational decoder for a seven-bit code that corrects one flipped bit. The encoder takes a four-bit message and places it into a seven-bit codeword. Three even-parity check bits fill the power-of-two positions. The decoder takes a received seven-bit word and forms a three-bit syndrome. It inverts the single position that the syndrome names and returns three results: the repaired codeword, the recovered message and an error flag.

Both halves share one set of check groups. A parameter places a clock-enabled output register behind every output, or leaves the whole block as pure logic. A surrounding datapath can therefore either absorb the decoder's XOR depth into the same cycle or cut it at the block boundary.

Codeword positions are numbered 1 to 7. Position p is carried on bit p-1 of every seven-bit port.

Top module: `hamming74_codec`

## Requirements
- R1: Message bit msg_in[3] goes to position 7, msg_in[2] to position 3, msg_in[1] to position 5 and msg_in[0] to position 6 of cw_out. On the port, position p is bit p-1.
- R2: Positions 1, 2 and 4 of cw_out hold even-parity bits over these check groups:
  - Group A is positions 1, 3, 5 and 7.
  - Group B is positions 2, 3, 6 and 7.
  - Group C is positions 4, 5, 6 and 7.
  Every group holds an even number of ones.
- R3: Message 4'b1001 encodes to cw_out = 7'b1100001, which puts parity values 1, 0 and 0 in positions 1, 2 and 4.
- R4: syn_out[0] is the parity of group A over rx_in, syn_out[1] is the parity of group B and syn_out[2] is the parity of group C. A valid codeword gives 3'b000. A single flip at position p gives syn_out = p; for example, position 3 gives 3'b011 and position 7 gives 3'b111.
- R5: err_out is 1 exactly when syn_out is non-zero.
- R6: fix_out equals rx_in with position syn_out inverted when syn_out is non-zero, and equals rx_in otherwise. Any codeword with at most one flipped bit is restored to the original codeword.
- R7: msg_out is taken from positions 7, 3, 5 and 6 of fix_out, in that order, into msg_out[3] down to msg_out[0].
- R8: With REG_OUT = 1, all outputs are zero while rst_n is low. On a rising clk edge with en high, the outputs load the values for the current inputs. With en low, the outputs hold.
- R9: With REG_OUT = 0, all outputs follow the inputs without a clock edge, and rst_n and en have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| en | input | 1 | Load enable of the output register |
| msg_in | input | 4 | Message to encode |
| rx_in | input | 7 | Received word to decode |
| cw_out | output | 7 | Encoded codeword |
| syn_out | output | 3 | Syndrome of rx_in |
| fix_out | output | 7 | Corrected codeword |
| msg_out | output | 4 | Message recovered from fix_out |
| err_out | output | 1 | Single-bit error flag |

## Verification
The bench builds two copies of the block side by side and drives both from the same stimulus. One copy uses REG_OUT = 1, which exposes the reset value, the load-enable and the hold behaviour. The other uses REG_OUT = 0, where the outputs must already be valid while reset is held. Both copies sweep all sixteen messages, each with a clean word and with a flip at each of the seven positions. Every syndrome value and every corrected position is therefore reached.

// File: rtl/hamming74_pkg.sv
package hamming74_pkg;

  localparam int CW_W  = 7;
  localparam int MSG_W = 4;
  localparam int CHK_W = 3;

  typedef logic [CW_W-1:0]  cw_t;
  typedef logic [MSG_W-1:0] msg_t;
  typedef logic [CHK_W-1:0] syn_t;

  // Position (1-based) that carries message bit MSG_W-1-j.
  localparam int MSG_POS [MSG_W] = '{7, 3, 5, 6};

  // Positions whose index has bit k set form check group k.
  function automatic cw_t group_mask(input int k);
    cw_t m;
    for (int i = 0; i < CW_W; i++) begin
      m[i] = (((i + 1) >> k) & 1) != 0;
    end
    return m;
  endfunction

  typedef struct packed {
    cw_t  cw;
    syn_t syn;
    cw_t  fix;
    msg_t msg;
    logic err;
  } codec_out_t;

endpackage

// File: rtl/hamming74_enc.sv
module hamming74_enc
  import hamming74_pkg::*;
(
  input  msg_t msg,
  output cw_t  cw
);

  cw_t placed;

  always_comb begin
    placed = '0;
    for (int j = 0; j < MSG_W; j++) begin
      placed[MSG_POS[j]-1] = msg[MSG_W-1-j];
    end
  end

  // Parity slots are zero in placed, so the group XOR yields the check bit.
  logic [CHK_W-1:0] par;
  for (genvar k = 0; k < CHK_W; k++) begin : g_par
    assign par[k] = ^(placed & group_mask(k));
  end

  always_comb begin
    cw = placed;
    for (int k = 0; k < CHK_W; k++) begin
      cw[(1 << k) - 1] = par[k];
    end
  end

endmodule

// File: rtl/hamming74_syn.sv
module hamming74_syn
  import hamming74_pkg::*;
(
  input  cw_t  rx,
  output syn_t syn
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    assign syn[k] = ^(rx & group_mask(k));
  end

endmodule

// File: rtl/hamming74_fix.sv
module hamming74_fix
  import hamming74_pkg::*;
(
  input  cw_t  rx,
  input  syn_t syn,
  output cw_t  fix,
  output msg_t msg,
  output logic err
);

  assign err = |syn;

  for (genvar i = 0; i < CW_W; i++) begin : g_flip
    assign fix[i] = rx[i] ^ (syn == syn_t'(i + 1));
  end

  for (genvar j = 0; j < MSG_W; j++) begin : g_msg
    assign msg[MSG_W-1-j] = fix[MSG_POS[j]-1];
  end

endmodule

// File: rtl/hamming74_codec.sv
module hamming74_codec
  import hamming74_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MSG_W-1:0] msg_in,
  input  logic [CW_W-1:0]  rx_in,
  output logic [CW_W-1:0]  cw_out,
  output logic [CHK_W-1:0] syn_out,
  output logic [CW_W-1:0]  fix_out,
  output logic [MSG_W-1:0] msg_out,
  output logic             err_out
);

  codec_out_t comb_o;
  codec_out_t out_o;

  hamming74_enc enc_i (
    .msg (msg_in),
    .cw  (comb_o.cw)
  );

  hamming74_syn syn_i (
    .rx  (rx_in),
    .syn (comb_o.syn)
  );

  hamming74_fix fix_i (
    .rx  (rx_in),
    .syn (comb_o.syn),
    .fix (comb_o.fix),
    .msg (comb_o.msg),
    .err (comb_o.err)
  );

  if (REG_OUT) begin : g_reg
    codec_out_t q_r;
    codec_out_t q_nxt;

    always_comb begin
      q_nxt = q_r;
      if (en) begin
        q_nxt = comb_o;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_r <= '0;
      end else begin
        q_r <= q_nxt;
      end
    end

    assign out_o = q_r;
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = &{1'b0, clk, rst_n, en};
    assign out_o = comb_o;
  end

  assign cw_out  = out_o.cw;
  assign syn_out = out_o.syn;
  assign fix_out = out_o.fix;
  assign msg_out = out_o.msg;
  assign err_out = out_o.err;

endmodule

// File: rtl/hamming74_codec_chk.sv
module hamming74_codec_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic [3:0] msg_in,
  input logic [6:0] rx_in,
  input logic [6:0] cw_out,
  input logic [2:0] syn_out,
  input logic [6:0] fix_out,
  input logic [3:0] msg_out,
  input logic       err_out
);

  // R2: every check group of the produced codeword is even
  p_cw_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cw_out[0] ^ cw_out[2] ^ cw_out[4] ^ cw_out[6]) == 1'b0) &&
    ((cw_out[1] ^ cw_out[2] ^ cw_out[5] ^ cw_out[6]) == 1'b0) &&
    ((cw_out[3] ^ cw_out[4] ^ cw_out[5] ^ cw_out[6]) == 1'b0));

  // R6: the corrected word is always a valid codeword
  p_fix_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((fix_out[0] ^ fix_out[2] ^ fix_out[4] ^ fix_out[6]) == 1'b0) &&
    ((fix_out[1] ^ fix_out[2] ^ fix_out[5] ^ fix_out[6]) == 1'b0) &&
    ((fix_out[3] ^ fix_out[4] ^ fix_out[5] ^ fix_out[6]) == 1'b0));

  // R5: flag agrees with the syndrome
  p_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_out == (syn_out != 3'b000));

  // R7: recovered message matches the corrected word
  p_msg_pick_r7: assert property (@(posedge clk) disable iff (!rst_n)
    msg_out == {fix_out[6], fix_out[2], fix_out[4], fix_out[5]});

  if (REG_OUT) begin : g_reg_chk
    // R8: outputs hold while the enable is low
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(cw_out) && $stable(fix_out) && $stable(syn_out)));

    // R1: a loaded codeword carries the message in its data slots
    p_place_r1: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (cw_out[6] == $past(msg_in[3])) && (cw_out[2] == $past(msg_in[2])) &&
             (cw_out[4] == $past(msg_in[1])) && (cw_out[5] == $past(msg_in[0])));

    // R6: a loaded correction is within one bit of the received word
    p_fix_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> ($countones(fix_out ^ $past(rx_in)) <= 1));
  end else begin : g_comb_chk
    // R1: data slots carry the message
    p_place_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_out[6] == msg_in[3]) && (cw_out[2] == msg_in[2]) &&
      (cw_out[4] == msg_in[1]) && (cw_out[5] == msg_in[0]));

    // R6: the correction is within one bit of the received word
    p_fix_near_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(fix_out ^ rx_in) <= 1) && (en || !en));
  end

endmodule

bind hamming74_codec hamming74_codec_chk #(.REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/hamming74_codec_tb_top.sv
`timescale 1ns/1ps
module hamming74_codec_tb_top;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [3:0] msg_in;
  logic [6:0] rx_in;

  logic [6:0] r_cw, r_fix, c_cw, c_fix;
  logic [2:0] r_syn, c_syn;
  logic [3:0] r_msg, c_msg;
  logic       r_err, c_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  hamming74_codec #(.REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .msg_in(msg_in), .rx_in(rx_in),
    .cw_out(r_cw), .syn_out(r_syn), .fix_out(r_fix), .msg_out(r_msg), .err_out(r_err)
  );

  hamming74_codec #(.REG_OUT(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .en(en), .msg_in(msg_in), .rx_in(rx_in),
    .cw_out(c_cw), .syn_out(c_syn), .fix_out(c_fix), .msg_out(c_msg), .err_out(c_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Model: position p lives on bit p-1; parity by counting ones per group.
  function automatic logic [6:0] model_enc(input logic [3:0] m);
    logic [6:0] w;
    int cnt;
    w = '0;
    w[6] = m[3];
    w[2] = m[2];
    w[4] = m[1];
    w[5] = m[0];
    for (int p = 1; p <= 4; p = p * 2) begin
      cnt = 0;
      for (int q = 1; q <= 7; q++) begin
        if ((q & p) != 0 && q != p && w[q-1]) cnt++;
      end
      w[p-1] = (cnt % 2) == 1;
    end
    return w;
  endfunction

  function automatic int group_ones(input logic [6:0] w, input int p);
    int cnt = 0;
    for (int q = 1; q <= 7; q++) begin
      if ((q & p) != 0 && w[q-1]) cnt++;
    end
    return cnt % 2;
  endfunction

  task automatic check_set(input string who, input logic [6:0] cw, input logic [2:0] syn,
                           input logic [6:0] fix, input logic [3:0] msg, input logic err,
                           input logic [3:0] m, input int e);
    logic [6:0] good;
    good = model_enc(m);
    check({who, " R1 codeword"}, 32'(cw), 32'(good));
    check({who, " R2 parity groups"},
          32'(group_ones(cw, 1) + group_ones(cw, 2) + group_ones(cw, 4)), 32'd0);
    check({who, " R4 syndrome"}, 32'(syn), 32'(e));
    check({who, " R5 flag"}, 32'(err), 32'(e != 0));
    check({who, " R6 corrected"}, 32'(fix), 32'(good));
    check({who, " R7 message"}, 32'(msg), 32'(m));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [6:0] rx;
    rst_n = 1'b0;
    en = 1'b0;
    msg_in = 4'd0;
    rx_in = 7'd0;
    repeat (2) @(negedge clk);
    // R8: registered copy zero in reset even with enable high
    msg_in = 4'b1001;
    rx_in = 7'b1100001 ^ 7'b0000100;
    en = 1'b1;
    @(negedge clk);
    check("R8 reset cw", 32'(r_cw), 32'd0);
    check("R8 reset fix", 32'(r_fix), 32'd0);
    check("R8 reset err", 32'(r_err), 32'd0);
    // R9: combinational copy valid during reset
    check("R9 comb in reset cw", 32'(c_cw), 32'h61);
    check("R9 comb in reset syn", 32'(c_syn), 32'd3);
    check("R9 comb in reset fix", 32'(c_fix), 32'h61);
    rst_n = 1'b1;
    @(negedge clk);
    // R3: worked example after one enabled edge
    check("R3 example codeword", 32'(r_cw), 32'b1100001);
    check("R4 flip at 3 syndrome", 32'(r_syn), 32'b011);

    for (int m = 0; m < 16; m++) begin
      for (int e = 0; e < 8; e++) begin
        rx = model_enc(4'(m));
        if (e != 0) rx[e-1] = ~rx[e-1];
        @(negedge clk);
        msg_in = 4'(m);
        rx_in = rx;
        #1;
        check_set("comb R9", c_cw, c_syn, c_fix, c_msg, c_err, 4'(m), e);
        @(negedge clk);
        check_set("reg R8", r_cw, r_syn, r_fix, r_msg, r_err, 4'(m), e);
      end
    end

    // R8: hold with enable low
    @(negedge clk);
    msg_in = 4'b1001;
    rx_in = 7'b1100001;
    @(negedge clk);
    en = 1'b0;
    msg_in = 4'b0110;
    rx_in = model_enc(4'b0110) ^ 7'b1000000;
    @(negedge clk);
    @(negedge clk);
    check("R8 hold cw", 32'(r_cw), 32'h61);
    check("R8 hold syn", 32'(r_syn), 32'd0);
    check("R8 hold err", 32'(r_err), 32'd0);
    check("R9 comb ignores en syn", 32'(c_syn), 32'd7);
    check("R9 comb ignores en msg", 32'(c_msg), 32'b0110);
    en = 1'b1;
    @(negedge clk);
    check("R8 reload syn", 32'(r_syn), 32'd7);
    check("R8 reload msg", 32'(r_msg), 32'b0110);
    check("R8 reload cw", 32'(r_cw), 32'(model_enc(4'b0110)));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule